// File: doc/BRIEF.md
# Supervisor interrupt domain selector

This block sits next to a hart's control and status registers and chooses which one of several supervisor interrupt domains feeds the hart's supervisor-level and guest external interrupt inputs. A small domain-select register names the active domain. Each implemented domain owns its own guest-enable register, and the hart-visible guest-pending and guest-enable views always show the pair that belongs to the selected domain. If the select register names a domain that does not exist, the views read as zero and the top-interrupt register cannot be reached.

Alongside the selection, every domain is folded into a 64-bit summary-pending register. A domain backed by a message-signalled interrupt file reports its supervisor pending line or any enabled pending guest file. A domain backed by a wired interrupt controller reports only its supervisor pending line. A 64-bit summary-enable register picks which domains may raise the machine-level domain summary interrupt at bit 14 of the interrupt pending word. Machine software uses that interrupt to learn that a domain not currently running has become ready. A delegation bit can expose bit 14 to supervisor level.

Top module: `sid_select`

## Requirements
- R1: The select register (address 0x7C0, bits SEL_W-1:0) resets to 0, holds any value from 0 to 2^SEL_W-1 and reads back what was written. Domains 0 to NDOM-1 are implemented.
- R2: While the select register names an unimplemented domain, `seip_o` is 0, the guest-pending view (0x7C1) and guest-enable view (0x7C2) read 0, and the guest-file selector (0x7C3, bits 5:0) reads 0 and ignores writes.
- R3: Any access to the top-interrupt register (0x7C4) raises `csr_illegal_o` while the selected domain is unimplemented. Any access to an address not listed here raises it always.
- R4: Each implemented domain holds its own GEILEN-bit guest-enable register. The views show the selected domain's guest-pending inputs and guest enables at bits GEILEN:1, with bit 0 always 0. A write to 0x7C2 changes only the selected domain's enables and is discarded when the selection is unimplemented. The stored enables survive a change of selection.
- R5: Summary bit i (i < NDOM) is the domain's SEIP input OR'd with any bit of (guest-pending AND guest-enable) for a message-signalled domain, and is the SEIP input alone for a domain whose APLIC_MASK bit is 1. Bits NDOM and above are 0. None of this depends on the selection.
- R6: The summary-pending register is read-only. Bits 31:0 are at 0x7C8 and bits 63:32 at 0x7C9.
- R7: The summary-enable register (0x7CA low half, 0x7CB high half) is writable only for bits below NDOM. Other bits read 0. It has no effect on `seip_o` or on the guest views.
- R8: `sdi_pend_o` and bit 14 of the machine pending word (0x7D0) are 1 exactly when summary-pending AND summary-enable is nonzero. Bit 9 of that word equals `seip_o`. The machine enable word (0x7D1) has only bit 14 writable.
- R9: With bit 14 of the machine delegation word (0x7D2) clear, bit 14 of the supervisor pending (0x7D3) and enable (0x7D4) words reads 0 and supervisor writes to it are ignored. With the bit set, both alias the machine bits, and a supervisor enable write updates the machine enable.
- R10: The hypervisor delegation word (0x7D5) always reads 0, bit 14 included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dom_seip_i | input | NDOM | Supervisor external pending line of each domain |
| dom_gp_i | input | NDOM*GEILEN | Guest-file pending lines, GEILEN per domain, domain 0 lowest |
| csr_re_i | input | 1 | Read strobe |
| csr_we_i | input | 1 | Write strobe |
| csr_addr_i | input | 12 | Register address |
| csr_wdata_i | input | 32 | Write data |
| csr_rdata_o | output | 32 | Read data, combinational |
| csr_illegal_o | output | 1 | Access must trap as an illegal instruction |
| seip_o | output | 1 | Supervisor external pending of the selected domain |
| sdi_pend_o | output | 1 | Machine-level domain summary interrupt pending (bit 14) |

## Verification
The assertions watch on every cycle the rules that hold cycle by cycle. The select register moves only on its own write. Guest enables stay untouched by a write aimed at a missing domain. Upper summary-enable bits stay zero. Clearing the enables drops the summary interrupt. A missing domain always traps the top-interrupt access and blanks the guest view. The hypervisor delegation word and an undelegated supervisor bit 14 read zero. Only the bench's scenarios can show that enables are kept per domain across selection changes, that each domain's summary bit follows its backing type under random inputs, and that the delegation alias is carried through a supervisor write.

// File: rtl/sid_select_pkg.sv
package sid_select_pkg;
    localparam logic [11:0] A_SEL    = 12'h7C0;
    localparam logic [11:0] A_GPEND  = 12'h7C1;
    localparam logic [11:0] A_GEN    = 12'h7C2;
    localparam logic [11:0] A_VGSEL  = 12'h7C3;
    localparam logic [11:0] A_TOPEI  = 12'h7C4;
    localparam logic [11:0] A_SUMP   = 12'h7C8;
    localparam logic [11:0] A_SUMPH  = 12'h7C9;
    localparam logic [11:0] A_SUME   = 12'h7CA;
    localparam logic [11:0] A_SUMEH  = 12'h7CB;
    localparam logic [11:0] A_MIP    = 12'h7D0;
    localparam logic [11:0] A_MIE    = 12'h7D1;
    localparam logic [11:0] A_MDELEG = 12'h7D2;
    localparam logic [11:0] A_SIP    = 12'h7D3;
    localparam logic [11:0] A_SIE    = 12'h7D4;
    localparam logic [11:0] A_HDELEG = 12'h7D5;

    localparam int unsigned BIT_SEI = 9;
    localparam int unsigned BIT_SDI = 14;
    localparam int unsigned SUMW    = 64;
endpackage

// File: rtl/sid_select_bank.sv
module sid_select_bank #(
    parameter int NDOM   = 5,
    parameter int GEILEN = 6,
    parameter int SEL_W  = 3
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic [SEL_W-1:0]         sel_i,
    input  logic                     sel_ok_i,
    input  logic                     gen_we_i,
    input  logic [GEILEN-1:0]        gen_wdata_i,
    input  logic [NDOM*GEILEN-1:0]   gp_i,
    output logic [GEILEN-1:0]        gp_view_o,
    output logic [GEILEN-1:0]        ge_view_o,
    output logic [NDOM-1:0]          hit_o
);
    localparam int FLATW = NDOM * GEILEN;

    logic [FLATW-1:0] en_flat;

    for (genvar d = 0; d < NDOM; d++) begin : g_dom
        logic [GEILEN-1:0] en_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                en_q <= '0;
            end else if (gen_we_i && sel_ok_i && (sel_i == SEL_W'(d))) begin
                en_q <= gen_wdata_i;
            end
        end
        assign en_flat[d*GEILEN +: GEILEN] = en_q;
        assign hit_o[d] = |(gp_i[d*GEILEN +: GEILEN] & en_q);
    end

    always_comb begin
        gp_view_o = '0;
        ge_view_o = '0;
        for (int d = 0; d < NDOM; d++) begin
            if (sel_ok_i && (sel_i == SEL_W'(d))) begin
                gp_view_o = gp_i[d*GEILEN +: GEILEN];
                ge_view_o = en_flat[d*GEILEN +: GEILEN];
            end
        end
    end

    // R4
    gen_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gen_we_i && !sel_ok_i) |=> $stable(en_flat));

    // R2
    view_blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sel_ok_i |-> (gp_view_o == '0 && ge_view_o == '0));
endmodule

// File: rtl/sid_select_summary.sv
module sid_select_summary
    import sid_select_pkg::*;
#(
    parameter int              NDOM       = 5,
    parameter logic [NDOM-1:0] APLIC_MASK = '0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [NDOM-1:0]  seip_i,
    input  logic [NDOM-1:0]  hit_i,
    input  logic             ewr_lo_i,
    input  logic             ewr_hi_i,
    input  logic [31:0]      wdata_i,
    output logic [SUMW-1:0]  sump_o,
    output logic [SUMW-1:0]  sume_o,
    output logic             irq_o
);
    localparam logic [SUMW-1:0] IMPL =
        (NDOM >= SUMW) ? '1 : ((SUMW'(1) << NDOM) - SUMW'(1));

    logic [SUMW-1:0] sume_q;
    logic [NDOM-1:0] dom_bit;

    for (genvar d = 0; d < NDOM; d++) begin : g_sum
        if (APLIC_MASK[d]) begin : g_wired
            assign dom_bit[d] = seip_i[d];
        end else begin : g_msg
            assign dom_bit[d] = seip_i[d] | hit_i[d];
        end
    end

    assign sump_o = SUMW'(dom_bit);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sume_q <= '0;
        end else if (ewr_lo_i) begin
            sume_q <= {sume_q[63:32], wdata_i} & IMPL;
        end else if (ewr_hi_i) begin
            sume_q <= {wdata_i, sume_q[31:0]} & IMPL;
        end
    end

    assign sume_o = sume_q;
    assign irq_o  = |(sump_o & sume_q);

    // R7
    sume_warl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sume_q & ~IMPL) == '0);

    // R8
    irq_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ewr_lo_i && wdata_i == 32'd0 && sume_q[63:32] == 32'd0) |=> !irq_o);
endmodule

// File: rtl/sid_select.sv
module sid_select
    import sid_select_pkg::*;
#(
    parameter int              NDOM       = 5,
    parameter int              SEL_W      = 3,
    parameter int              GEILEN     = 6,
    parameter int              VG_W       = 6,
    parameter logic [NDOM-1:0] APLIC_MASK = 'b00100
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic [NDOM-1:0]          dom_seip_i,
    input  logic [NDOM*GEILEN-1:0]   dom_gp_i,
    input  logic                     csr_re_i,
    input  logic                     csr_we_i,
    input  logic [11:0]              csr_addr_i,
    input  logic [31:0]              csr_wdata_i,
    output logic [31:0]              csr_rdata_o,
    output logic                     csr_illegal_o,
    output logic                     seip_o,
    output logic                     sdi_pend_o
);
    logic [SEL_W-1:0]  sel_q;
    logic [VG_W-1:0]   vg_q;
    logic              mie_q;
    logic              deleg_q;
    logic              sel_ok;

    logic              we_sel, we_gen, we_vg, we_elo, we_ehi;
    logic              we_mie, we_deleg, we_sie;

    logic [GEILEN-1:0] gp_view, ge_view;
    logic [NDOM-1:0]   hit;
    logic [SUMW-1:0]   sump, sume;
    logic [31:0]       rdata;
    logic              known;

    assign sel_ok = (int'(sel_q) < NDOM);

    // write strobes
    assign we_sel   = csr_we_i && (csr_addr_i == A_SEL);
    assign we_gen   = csr_we_i && (csr_addr_i == A_GEN);
    assign we_vg    = csr_we_i && (csr_addr_i == A_VGSEL) && sel_ok;
    assign we_elo   = csr_we_i && (csr_addr_i == A_SUME);
    assign we_ehi   = csr_we_i && (csr_addr_i == A_SUMEH);
    assign we_mie   = csr_we_i && (csr_addr_i == A_MIE);
    assign we_deleg = csr_we_i && (csr_addr_i == A_MDELEG);
    assign we_sie   = csr_we_i && (csr_addr_i == A_SIE) && deleg_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sel_q   <= '0;
            vg_q    <= '0;
            mie_q   <= 1'b0;
            deleg_q <= 1'b0;
        end else begin
            if (we_sel)   sel_q   <= csr_wdata_i[SEL_W-1:0];
            if (we_vg)    vg_q    <= csr_wdata_i[VG_W-1:0];
            if (we_deleg) deleg_q <= csr_wdata_i[BIT_SDI];
            if (we_mie || we_sie) mie_q <= csr_wdata_i[BIT_SDI];
        end
    end

    sid_select_bank #(
        .NDOM   (NDOM),
        .GEILEN (GEILEN),
        .SEL_W  (SEL_W)
    ) u_bank (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .sel_i       (sel_q),
        .sel_ok_i    (sel_ok),
        .gen_we_i    (we_gen),
        .gen_wdata_i (csr_wdata_i[GEILEN:1]),
        .gp_i        (dom_gp_i),
        .gp_view_o   (gp_view),
        .ge_view_o   (ge_view),
        .hit_o       (hit)
    );

    sid_select_summary #(
        .NDOM       (NDOM),
        .APLIC_MASK (APLIC_MASK)
    ) u_sum (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .seip_i   (dom_seip_i),
        .hit_i    (hit),
        .ewr_lo_i (we_elo),
        .ewr_hi_i (we_ehi),
        .wdata_i  (csr_wdata_i),
        .sump_o   (sump),
        .sume_o   (sume),
        .irq_o    (sdi_pend_o)
    );

    always_comb begin
        seip_o = 1'b0;
        for (int d = 0; d < NDOM; d++) begin
            if (sel_ok && (sel_q == SEL_W'(d))) seip_o = dom_seip_i[d];
        end
    end

    always_comb begin
        rdata = '0;
        known = 1'b1;
        case (csr_addr_i)
            A_SEL:    rdata = 32'(sel_q);
            A_GPEND:  rdata = 32'({gp_view, 1'b0});
            A_GEN:    rdata = 32'({ge_view, 1'b0});
            A_VGSEL:  rdata = sel_ok ? 32'(vg_q) : 32'd0;
            A_TOPEI:  rdata = 32'd0;
            A_SUMP:   rdata = sump[31:0];
            A_SUMPH:  rdata = sump[63:32];
            A_SUME:   rdata = sume[31:0];
            A_SUMEH:  rdata = sume[63:32];
            A_MIP: begin
                rdata[BIT_SEI] = seip_o;
                rdata[BIT_SDI] = sdi_pend_o;
            end
            A_MIE:    rdata[BIT_SDI] = mie_q;
            A_MDELEG: rdata[BIT_SDI] = deleg_q;
            A_SIP:    rdata[BIT_SDI] = deleg_q & sdi_pend_o;
            A_SIE:    rdata[BIT_SDI] = deleg_q & mie_q;
            A_HDELEG: rdata = 32'd0;
            default:  known = 1'b0;
        endcase
    end

    assign csr_rdata_o   = rdata;
    assign csr_illegal_o = (csr_re_i || csr_we_i) &&
                           (!known || ((csr_addr_i == A_TOPEI) && !sel_ok));

    // R1
    sel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !we_sel |=> $stable(sel_q));

    // R3
    topei_trap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_re_i && csr_addr_i == A_TOPEI && !sel_ok) |-> csr_illegal_o);

    // R2
    gpend_blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_re_i && csr_addr_i == A_GPEND && !sel_ok) |-> csr_rdata_o == 32'd0);

    // R9
    sie_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!deleg_q && csr_re_i && csr_addr_i == A_SIE) |-> !csr_rdata_o[BIT_SDI]);

    // R10
    hdeleg_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_re_i && csr_addr_i == A_HDELEG) |-> csr_rdata_o == 32'd0);
endmodule

// File: tb/tb_sid_select.sv
`timescale 1ns/1ps
module tb_sid_select;
    import sid_select_pkg::*;

    localparam int NDOM = 5;
    localparam int SEL_W = 3;
    localparam int GEILEN = 6;
    localparam logic [NDOM-1:0] APLIC = 5'b00100;
    localparam logic [63:0] IMPL = 64'h1F;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [NDOM-1:0]        seip_v = '0;
    logic [NDOM*GEILEN-1:0] gp_v = '0;
    logic        re = 1'b0, we = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        illegal, seip, sdi;

    int nchk = 0;
    int nfail = 0;
    bit running = 1'b0;

    // reference model state
    int          sel_m = 0;
    logic [GEILEN-1:0] en_m [0:7];
    logic [5:0]  vg_m = '0;
    logic [63:0] sume_m = '0;
    logic        mie_m = 1'b0;
    logic        deleg_m = 1'b0;

    sid_select dut (
        .clk_i(clk), .rst_ni(rst_n),
        .dom_seip_i(seip_v), .dom_gp_i(gp_v),
        .csr_re_i(re), .csr_we_i(we), .csr_addr_i(addr), .csr_wdata_i(wdata),
        .csr_rdata_o(rdata), .csr_illegal_o(illegal),
        .seip_o(seip), .sdi_pend_o(sdi)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit ok_m();
        return sel_m < NDOM;
    endfunction

    function automatic logic exp_seip();
        return ok_m() ? seip_v[sel_m] : 1'b0;
    endfunction

    function automatic logic [63:0] exp_sump();
        logic [63:0] r = '0;
        for (int d = 0; d < NDOM; d++) begin
            logic [GEILEN-1:0] g = gp_v[d*GEILEN +: GEILEN];
            r[d] = seip_v[d] | (APLIC[d] ? 1'b0 : |(g & en_m[d]));
        end
        return r;
    endfunction

    function automatic logic exp_sdi();
        return |(exp_sump() & sume_m);
    endfunction

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        logic [31:0] r = '0;
        case (a)
            A_SEL:    r = 32'(sel_m);
            A_GPEND:  if (ok_m()) r = 32'({gp_v[sel_m*GEILEN +: GEILEN], 1'b0});
            A_GEN:    if (ok_m()) r = 32'({en_m[sel_m], 1'b0});
            A_VGSEL:  if (ok_m()) r = 32'(vg_m);
            A_SUMP:   r = exp_sump()[31:0];
            A_SUMPH:  r = exp_sump()[63:32];
            A_SUME:   r = sume_m[31:0];
            A_SUMEH:  r = sume_m[63:32];
            A_MIP:    begin r[9] = exp_seip(); r[14] = exp_sdi(); end
            A_MIE:    r[14] = mie_m;
            A_MDELEG: r[14] = deleg_m;
            A_SIP:    r[14] = deleg_m & exp_sdi();
            A_SIE:    r[14] = deleg_m & mie_m;
            default:  r = '0;
        endcase
        return r;
    endfunction

    function automatic logic exp_ill(input logic [11:0] a);
        case (a)
            A_SEL, A_GPEND, A_GEN, A_VGSEL, A_SUMP, A_SUMPH, A_SUME, A_SUMEH,
            A_MIP, A_MIE, A_MDELEG, A_SIP, A_SIE, A_HDELEG: return 1'b0;
            A_TOPEI: return !ok_m();
            default: return 1'b1;
        endcase
    endfunction

    task automatic model_write(input logic [11:0] a, input logic [31:0] d);
        case (a)
            A_SEL:    sel_m = int'(d[SEL_W-1:0]);
            A_GEN:    if (ok_m()) en_m[sel_m] = d[GEILEN:1];
            A_VGSEL:  if (ok_m()) vg_m = d[5:0];
            A_SUME:   sume_m[31:0]  = d & IMPL[31:0];
            A_SUMEH:  sume_m[63:32] = d & IMPL[63:32];
            A_MIE:    mie_m = d[14];
            A_MDELEG: deleg_m = d[14];
            A_SIE:    if (deleg_m) mie_m = d[14];
            default:  ;
        endcase
    endtask

    task automatic csr_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        re = 1'b0; we = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        model_write(a, d);
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic csr_rd(input string req, input logic [11:0] a);
        @(negedge clk);
        we = 1'b0; re = 1'b1; addr = a;
        #1.5;
        chk(req, 64'(rdata), 64'(exp_read(a)));
        chk(req, 64'(illegal), 64'(exp_ill(a)));
    endtask

    task automatic shake();
        @(negedge clk);
        seip_v = NDOM'($urandom);
        gp_v = (NDOM*GEILEN)'($urandom);
    endtask

    // compared on every clock
    always @(negedge clk) begin
        if (running) begin
            #1;
            chk("R2 R8 seip_o", 64'(seip), 64'(exp_seip()));
            chk("R5 R8 sdi_pend_o", 64'(sdi), 64'(exp_sdi()));
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) en_m[i] = '0;
        void'($urandom(32'd7));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        running = 1'b1;

        // reset state
        csr_rd("R1 reset select", A_SEL);
        csr_rd("R6 reset summary", A_SUMP);
        csr_rd("R8 reset mip", A_MIP);
        csr_rd("R10 hdeleg", A_HDELEG);

        // sweep every select value, including unimplemented ones
        for (int s = 0; s < 8; s++) begin
            csr_wr(A_SEL, 32'(s) | 32'hFFFF_FFF8);
            csr_rd("R1 select readback", A_SEL);
            csr_wr(A_GEN, $urandom);
            csr_wr(A_VGSEL, $urandom);
            csr_wr(A_SUME, $urandom);
            for (int k = 0; k < 6; k++) begin
                shake();
                csr_rd("R4 R2 guest pending view", A_GPEND);
                csr_rd("R4 R2 guest enable view", A_GEN);
                csr_rd("R2 guest file selector", A_VGSEL);
                csr_rd("R3 top interrupt", A_TOPEI);
                csr_rd("R5 R6 summary low", A_SUMP);
                csr_rd("R6 summary high", A_SUMPH);
                csr_rd("R8 machine pending", A_MIP);
            end
        end

        // enables survive a change of selection
        for (int s = 0; s < NDOM; s++) begin
            csr_wr(A_SEL, 32'(s));
            shake();
            csr_rd("R4 retained enable", A_GEN);
        end

        // summary enable write-any-read-legal
        csr_wr(A_SUME, 32'hFFFF_FFFF);
        csr_rd("R7 enable low mask", A_SUME);
        csr_wr(A_SUMEH, 32'hFFFF_FFFF);
        csr_rd("R7 enable high zero", A_SUMEH);
        csr_wr(A_SUMP, 32'h0);
        csr_rd("R6 read-only summary", A_SUMP);
        shake();
        csr_wr(A_SUME, 32'h0);
        csr_rd("R8 cleared enable", A_MIP);

        // only domain 2 enabled, wired domain ignores guest lines
        csr_wr(A_SUME, 32'h4);
        csr_wr(A_SEL, 32'd2);
        csr_wr(A_GEN, 32'h7E);
        @(negedge clk);
        seip_v = '0; gp_v = '1;
        csr_rd("R5 wired domain guest ignored", A_SUMP);
        @(negedge clk);
        seip_v = 5'b00100;
        csr_rd("R5 R8 wired domain seip", A_MIP);
        csr_wr(A_SUME, 32'h0);
        csr_rd("R7 enable does not gate seip", A_MIP);

        // delegation of bit 14
        csr_wr(A_SUME, 32'h1F);
        csr_wr(A_MIE, 32'h0000_4000);
        csr_rd("R8 machine enable", A_MIE);
        csr_rd("R9 sip undelegated", A_SIP);
        csr_rd("R9 sie undelegated", A_SIE);
        csr_wr(A_SIE, 32'h0);
        csr_rd("R9 sie write ignored", A_MIE);
        csr_wr(A_MDELEG, 32'h0000_4000);
        csr_rd("R9 sip alias", A_SIP);
        csr_rd("R9 sie alias", A_SIE);
        csr_wr(A_SIE, 32'h0);
        csr_rd("R9 sie write reaches mie", A_MIE);
        csr_wr(A_HDELEG, 32'hFFFF_FFFF);
        csr_rd("R10 hdeleg after write", A_HDELEG);

        // unknown address
        csr_rd("R3 unknown address", 12'h7EE);
        csr_wr(A_SEL, 32'd6);
        csr_wr(A_VGSEL, 32'h15);
        csr_wr(A_SEL, 32'd1);
        csr_rd("R2 selector write ignored", A_VGSEL);

        @(negedge clk);
        re = 1'b0;
        running = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule